// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs the bus cycles of an 8-bit controller's external memory interface. The core hands it one request at a time over a ready/valid handshake. A request is a code fetch, a data read or a data write, and it carries an address and, for writes, a data byte. The block then drives a shared port that carries the low address byte and the data byte at different times. It also drives a separate high address port, an address latch enable, and three active-low strobes: one for program store (code fetches), one for data reads and one for data writes. Bytes read from the bus are returned to the core.

Every bus cycle passes through four timed phases after it is accepted. In the address phase the latch enable is high while the shared port carries the low address byte. In the hold phase the latch enable is low and the low address is still driven. In the strobe phase one strobe is low: the shared port is released for fetches and reads, and carries the write byte for writes. In the release phase all strobes are high and the port is released. The length of each phase is a parameter.

The high port is fixed for the whole cycle. Fetches and 16-bit pointer accesses put the upper address byte on it. 8-bit register-indirect accesses instead keep the port-2 latch value that was present when the request was accepted. While the block is idle, the high port shows the port-2 latch.

Top module: `xbus_seq`

States: `S_IDLE`, `S_ADDR`, `S_HOLD`, `S_STRB`, `S_REL`. Transitions:
- `S_IDLE`→`S_ADDR` on an accepted request.
- `S_ADDR`→`S_HOLD`, `S_HOLD`→`S_STRB`, `S_STRB`→`S_REL` and `S_REL`→`S_IDLE`, each when the phase counter of the current state expires.

Request kinds are coded on `req_kind`: 0 = fetch, 1 = data read, 2 = data write.

## Requirements
- R1: After reset and whenever idle: `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `req_ready` is 1 and `done` is 0.
- R2: In each cycle `ale` is high for exactly ADDR_CYC consecutive clocks. During that time `ad_oe` is 1 and `ad_out` is the low address byte (`req_addr[7:0]`).
- R3: After `ale` falls, the low address stays driven for HOLD_CYC clocks with all strobes high, before any strobe goes low.
- R4: `hi_addr` does not change during a cycle. It equals `req_addr[15:8]` for fetches and for accesses with `req_wide`=1. It equals the `p2_latch` value sampled at acceptance for data accesses with `req_wide`=0.
- R5: A fetch holds `psen_n` low for exactly STRB_CYC clocks while `rd_n` and `wr_n` stay high. `rdata` returns `ad_in` as sampled on the last strobe clock.
- R6: A data read holds `rd_n` low for exactly STRB_CYC clocks while `psen_n` and `wr_n` stay high. `rdata` returns `ad_in` as sampled on the last strobe clock.
- R7: A data write holds `wr_n` low for exactly STRB_CYC clocks. For that whole time `ad_oe` is 1 and `ad_out` equals `req_wdata`.
- R8: At most one strobe is low at a time. No strobe is low while `ale` is high. `ad_oe` is 0 while `psen_n` or `rd_n` is low.
- R9: `done` is a one-clock pulse. It appears on the ADDR_CYC+HOLD_CYC+STRB_CYC+REL_CYC-th clock after the accepting edge, and `rdata` is valid in that clock.
- R10: `req_ready` is 0 from acceptance through the `done` clock. A request held valid meanwhile is not started until the current cycle ends. It is then accepted on the clock after `done`, so its `ale` appears two clocks after `done`.
- R11: After a data cycle, a fetch drives the fetch address: the low byte on the shared port under `ale` and the high byte on `hi_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_kind | input | 2 | 0 fetch, 1 data read, 2 data write |
| req_wide | input | 1 | 1: 16-bit pointer address, 0: 8-bit register address |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| p2_latch | input | 8 | Current port-2 latch contents |
| rdata | output | 8 | Byte captured from the bus |
| done | output | 1 | End-of-cycle pulse |
| ad_out | output | 8 | Shared low address / data port, output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input value |
| hi_addr | output | 8 | High address port |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The end of one bus cycle (the `done` pulse) can coincide with a new request that the core has been holding valid. The bench provokes this by raising a second request while the first is still in its address phase and keeping it valid through the first cycle's `done`. It then checks that `req_ready` stayed low all that time, that the latch enable rose only once during the first cycle, and that the second cycle's latch enable appears exactly two clocks after `done`. It also checks that each cycle returns its own byte, even though the request fields changed while the first cycle was in flight.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        K_FETCH = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ADDR = 3'd1,
        S_HOLD = 3'd2,
        S_STRB = 3'd3,
        S_REL  = 3'd4
    } state_e;
endpackage

// File: rtl/xbus_phase_cnt.sv
module xbus_phase_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/xbus_addr_sel.sv
module xbus_addr_sel
    import xbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  kind_e           kind,
    input  logic            wide,
    input  logic [2*DW-1:0] addr,
    input  logic [DW-1:0]   port_latch,
    input  logic [DW-1:0]   wdata,
    output kind_e           kind_q,
    output logic [DW-1:0]   lo_q,
    output logic [DW-1:0]   hi_q,
    output logic [DW-1:0]   wd_q
);
    logic [DW-1:0] hi_src;

    // Fetches always use the full address; data accesses pick pointer or latch.
    assign hi_src = (kind == K_FETCH || wide) ? addr[2*DW-1:DW] : port_latch;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= K_FETCH;
            lo_q   <= '0;
            hi_q   <= '0;
            wd_q   <= '0;
        end else if (capture) begin
            kind_q <= kind;
            lo_q   <= addr[DW-1:0];
            hi_q   <= hi_src;
            wd_q   <= wdata;
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_CYC = 2,
    parameter int HOLD_CYC = 1,
    parameter int STRB_CYC = 3,
    parameter int REL_CYC  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_kind,
    input  logic       req_wide,
    input  logic [15:0] req_addr,
    input  logic [7:0] req_wdata,
    input  logic [7:0] p2_latch,
    output logic [7:0] rdata,
    output logic       done,
    output logic [7:0] ad_out,
    output logic       ad_oe,
    input  logic [7:0] ad_in,
    output logic [7:0] hi_addr,
    output logic       ale,
    output logic       psen_n,
    output logic       rd_n,
    output logic       wr_n
);
    localparam int DW   = 8;
    localparam int M_AH = (ADDR_CYC > HOLD_CYC) ? ADDR_CYC : HOLD_CYC;
    localparam int M_SR = (STRB_CYC > REL_CYC) ? STRB_CYC : REL_CYC;
    localparam int MAXP = (M_AH > M_SR) ? M_AH : M_SR;
    localparam int CW   = $clog2(MAXP) + 1;
    localparam logic [CW-1:0] L_ADDR = CW'(ADDR_CYC - 1);
    localparam logic [CW-1:0] L_HOLD = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] L_STRB = CW'(STRB_CYC - 1);
    localparam logic [CW-1:0] L_REL  = CW'(REL_CYC - 1);

    state_e        state_q, state_d;
    logic          ph_load, ph_last;
    logic [CW-1:0] ph_val;
    logic          accept;
    kind_e         kind_q;
    logic [DW-1:0] lo_q, hi_q, wd_q, rdata_q;

    assign accept = (state_q == S_IDLE) && req_valid;

    xbus_addr_sel #(.DW(DW)) i_addr_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (accept),
        .kind       (kind_e'(req_kind)),
        .wide       (req_wide),
        .addr       (req_addr),
        .port_latch (p2_latch),
        .wdata      (req_wdata),
        .kind_q     (kind_q),
        .lo_q       (lo_q),
        .hi_q       (hi_q),
        .wd_q       (wd_q)
    );

    xbus_phase_cnt #(.CW(CW)) i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .last     (ph_last)
    );

    // Next state and phase counter load
    always_comb begin
        state_d = state_q;
        ph_load = 1'b0;
        ph_val  = '0;
        unique case (state_q)
            S_IDLE: if (req_valid) begin
                state_d = S_ADDR; ph_load = 1'b1; ph_val = L_ADDR;
            end
            S_ADDR: if (ph_last) begin
                state_d = S_HOLD; ph_load = 1'b1; ph_val = L_HOLD;
            end
            S_HOLD: if (ph_last) begin
                state_d = S_STRB; ph_load = 1'b1; ph_val = L_STRB;
            end
            S_STRB: if (ph_last) begin
                state_d = S_REL;  ph_load = 1'b1; ph_val = L_REL;
            end
            S_REL:  if (ph_last) begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Byte capture on the last strobe clock of a fetch or read
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (state_q == S_STRB && ph_last && kind_q != K_WRITE)
            rdata_q <= ad_in;
    end

    // Outputs
    always_comb begin
        ale       = 1'b0;
        ad_oe     = 1'b0;
        ad_out    = lo_q;
        psen_n    = 1'b1;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        done      = 1'b0;
        req_ready = 1'b0;
        hi_addr   = hi_q;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                hi_addr   = p2_latch;
            end
            S_ADDR: begin
                ale   = 1'b1;
                ad_oe = 1'b1;
            end
            S_HOLD: ad_oe = 1'b1;
            S_STRB: begin
                psen_n = (kind_q != K_FETCH);
                rd_n   = (kind_q != K_READ);
                wr_n   = (kind_q != K_WRITE);
                if (kind_q == K_WRITE) begin
                    ad_oe  = 1'b1;
                    ad_out = wd_q;
                end
            end
            S_REL: done = ph_last;
            default: req_ready = 1'b0;
        endcase
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       done,
    input logic       ad_oe,
    input logic [7:0] hi_addr,
    input logic       ale,
    input logic       psen_n,
    input logic       rd_n,
    input logic       wr_n
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ale && psen_n && rd_n && wr_n && !ad_oe && !done));

    p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    p_hold_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (psen_n && rd_n && wr_n && ad_oe));

    p_hi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(hi_addr));

    p_write_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    p_no_strobe_ale_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (psen_n && rd_n && wr_n));

    p_read_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !ad_oe);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
endmodule

bind xbus_seq xbus_seq_chk i_xbus_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .ad_oe     (ad_oe),
    .hi_addr   (hi_addr),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/test_xbus_seq.sv
module test_xbus_seq;
    localparam int A_C = 2, H_C = 1, S_C = 3, R_C = 1;
    localparam int TOTAL = A_C + H_C + S_C + R_C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_kind = 2'd0;
    logic req_wide = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] p2_latch = '0;
    logic [7:0] rdata, ad_out, ad_in, hi_addr;
    logic done, ad_oe, ale, psen_n, rd_n, wr_n;

    int n_total = 0, n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xbus_seq #(.ADDR_CYC(A_C), .HOLD_CYC(H_C), .STRB_CYC(S_C), .REL_CYC(R_C)) i_xbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .p2_latch(p2_latch), .rdata(rdata), .done(done),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .hi_addr(hi_addr),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    // External memory model with a transparent address latch
    logic [7:0] lo_lat = '0;
    logic [7:0] dmem [0:255];
    int n_ale, n_alerise, n_psen, n_rd, n_wr, n_wbad, n_hibad, n_aladdr;
    logic [7:0] hi_at_ale, hi_seen, wd_exp, wr_data, wr_hi;
    logic ale_prev = 1'b0, wr_prev = 1'b1;

    function automatic logic [7:0] code_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always_comb begin
        if (!psen_n)
            ad_in = code_byte({hi_addr, lo_lat});
        else if (!rd_n)
            ad_in = dmem[{hi_addr[3:0], lo_lat[3:0]}];
        else
            ad_in = 8'h00;
    end

    task automatic mon_clear();
        n_ale = 0; n_alerise = 0; n_psen = 0; n_rd = 0; n_wr = 0;
        n_wbad = 0; n_hibad = 0; n_aladdr = 0;
    endtask

    always @(negedge clk) begin
        if (ale) begin
            n_ale++;
            if (!ad_oe) n_aladdr++;
            lo_lat    = ad_out;
            hi_at_ale = hi_addr;
            if (!ale_prev) n_alerise++;
        end
        if (!psen_n || !rd_n || !wr_n) begin
            hi_seen = hi_addr;
            if (hi_addr != hi_at_ale) n_hibad++;
        end
        if (!psen_n) n_psen++;
        if (!rd_n) n_rd++;
        if (!wr_n) begin
            n_wr++;
            if (!ad_oe || ad_out != wd_exp) n_wbad++;
            wr_data = ad_out;
            wr_hi   = hi_addr;
        end
        if (wr_n && !wr_prev) dmem[{wr_hi[3:0], lo_lat[3:0]}] = wr_data;
        wr_prev  = wr_n;
        ale_prev = ale;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Issue one request and wait for its done pulse
    task automatic run_req(input logic [1:0] kind, input logic wide,
                           input logic [15:0] addr, input logic [7:0] wd,
                           input logic [7:0] p2, output logic [7:0] got,
                           output int lat);
        @(negedge clk);
        mon_clear();
        req_kind = kind; req_wide = wide; req_addr = addr;
        req_wdata = wd; p2_latch = p2; wd_exp = wd; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        got = rdata;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ale == 0 && ad_oe == 0, "R1", "ale/ad_oe after reset", {ale, ad_oe}, 0);
        chk(psen_n && rd_n && wr_n, "R1", "strobes after reset", {psen_n, rd_n, wr_n}, 7);
        chk(req_ready == 1 && done == 0, "R1", "ready/done after reset", {req_ready, done}, 2);
    endtask

    task automatic t_fetch();
        logic [7:0] got; int lat;
        run_req(2'd0, 1'b0, 16'h12A7, 8'h00, 8'hEE, got, lat);
        chk(got == code_byte(16'h12A7), "R5", "fetch byte", got, code_byte(16'h12A7));
        chk(n_psen == S_C && n_rd == 0 && n_wr == 0, "R5", "fetch strobe clocks", n_psen, S_C);
        chk(n_ale == A_C && n_aladdr == 0, "R2", "ale clocks", n_ale, A_C);
        chk(lo_lat == 8'hA7, "R2", "latched low address", lo_lat, 8'hA7);
        chk(hi_seen == 8'h12 && n_hibad == 0, "R4", "fetch high byte", hi_seen, 8'h12);
        chk(lat == TOTAL, "R9", "done latency", lat, TOTAL);
        @(negedge clk);
        chk(done == 0 && req_ready == 1, "R9", "done one clock", {done, req_ready}, 1);
        chk(ale == 0 && psen_n && !ad_oe, "R1", "idle after cycle", {ale, psen_n, ad_oe}, 2);
    endtask

    task automatic t_read_wide();
        logic [7:0] got; int lat;
        run_req(2'd1, 1'b1, 16'h0A06, 8'h00, 8'h33, got, lat);
        chk(got == dmem[8'hA6], "R6", "wide read byte", got, dmem[8'hA6]);
        chk(n_rd == S_C && n_psen == 0 && n_wr == 0, "R6", "read strobe clocks", n_rd, S_C);
        chk(hi_seen == 8'h0A && n_hibad == 0, "R4", "pointer high byte", hi_seen, 8'h0A);
    endtask

    task automatic t_read_narrow();
        logic [7:0] got; int lat;
        run_req(2'd1, 1'b0, 16'hF934, 8'h00, 8'h07, got, lat);
        chk(hi_seen == 8'h07 && n_hibad == 0, "R4", "latch kept on high port", hi_seen, 8'h07);
        chk(got == dmem[8'h74], "R6", "narrow read byte", got, dmem[8'h74]);
    endtask

    task automatic t_write();
        logic [7:0] got; int lat;
        run_req(2'd2, 1'b1, 16'h0305, 8'hC3, 8'h00, got, lat);
        chk(n_wr == S_C && n_psen == 0 && n_rd == 0, "R7", "write strobe clocks", n_wr, S_C);
        chk(n_wbad == 0, "R7", "write data driven", n_wbad, 0);
        chk(lat == TOTAL, "R9", "write latency", lat, TOTAL);
        run_req(2'd1, 1'b0, 16'h0005, 8'h00, 8'h03, got, lat);
        chk(got == 8'hC3, "R7", "write read back", got, 8'hC3);
    endtask

    task automatic t_fetch_after_data();
        logic [7:0] got; int lat;
        run_req(2'd1, 1'b0, 16'h0011, 8'h00, 8'h02, got, lat);
        run_req(2'd0, 1'b0, 16'h4A10, 8'h00, 8'h02, got, lat);
        chk(lo_lat == 8'h10 && hi_seen == 8'h4A, "R11", "fetch address after data",
            {hi_seen, lo_lat}, 16'h4A10);
        chk(got == code_byte(16'h4A10) && n_rd == 0, "R11", "fetch byte after data",
            got, code_byte(16'h4A10));
    endtask

    task automatic t_backpressure();
        int k, rdy_bad, gap;
        logic [7:0] got_a;
        @(negedge clk);
        mon_clear();
        req_kind = 2'd1; req_wide = 1'b1; req_addr = 16'h0102; p2_latch = 8'h00;
        req_valid = 1'b1;
        @(negedge clk);
        // second request held valid while the first is in flight
        req_kind = 2'd0; req_addr = 16'h2233;
        rdy_bad = 0; k = 1;
        while (!done && k < 100) begin
            if (req_ready) rdy_bad++;
            @(negedge clk);
            k++;
        end
        got_a = rdata;
        chk(rdy_bad == 0 && req_ready == 0, "R10", "ready low while busy", rdy_bad, 0);
        chk(n_alerise == 1, "R10", "single start while busy", n_alerise, 1);
        chk(got_a == dmem[8'h12], "R10", "first cycle byte kept", got_a, dmem[8'h12]);
        gap = 0;
        while (!ale && gap < 100) begin
            @(negedge clk);
            gap++;
        end
        req_valid = 1'b0;
        chk(gap == 2, "R10", "held request start gap", gap, 2);
        k = 0;
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk(rdata == code_byte(16'h2233), "R10", "held request byte", rdata, code_byte(16'h2233));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = 8'(i * 7 + 3);
        mon_clear();
        hi_at_ale = '0; hi_seen = '0; wd_exp = '0; wr_data = '0; wr_hi = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fetch();
        t_read_wide();
        t_read_narrow();
        t_write();
        t_fetch_after_data();
        t_backpressure();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_bad++;
            $display("FAIL R9 watchdog actual=0x%0h expected=0x%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end
endmodule